// File: doc/BRIEF.md
# Gray-Coded Pointer Crossing Between Clock Domains

This block moves a FIFO-style address pointer from a source clock domain into an unrelated destination clock domain. On the source side, a binary counter advances by one on each cycle in which its increment enable is high. A second register holds the Gray-coded form of the count. Both registers load on the same edge from the same next binary value, so the Gray form always matches the count and is never produced by logic fed from the live counter.

The Gray bus then crosses to the destination side through a chain of two flip-flops. After the chain, a prefix-XOR network turns it back into binary. Destination logic, such as a FIFO flag comparator, can then treat the pointer as an ordinary unsigned number. Between two consecutive counts only one Gray bit changes, including at the wrap from all-ones back to zero. A sample taken at any moment therefore decodes to either the previous pointer or the next one, never to a mixture of both. The width is a parameter so that one block serves FIFOs of different depths.

Top module: `gray_ptr_xfer`

## Requirements
- R1: Each domain has its own synchronous active-high reset. While `src_rst` is high at a `src_clk` edge, `src_bin` and `src_gray` become zero. While `dst_rst` is high at a `dst_clk` edge, both synchronizer stages clear, so `dst_bin` is zero.
- R2: At a `src_clk` edge with `src_inc` high, `src_bin` takes its previous value plus one. With `src_inc` low, `src_bin` and `src_gray` keep their values.
- R3: After every `src_clk` edge, `src_gray` equals `src_bin XOR (src_bin >> 1)`.
- R4: Between any two consecutive `src_clk` edges, `src_gray` changes in at most one bit position. Every increment changes exactly one bit.
- R5: The count wraps modulo 2^WIDTH. Incrementing from all ones gives zero, and `src_gray` moves from a one in only its MSB to all zeros.
- R6: Bit n of `dst_bin` is the XOR of bits WIDTH-1 down to n of the Gray value held in the second synchronizer stage. A change of `src_gray` that is stable before a `dst_clk` edge is not yet visible on `dst_bin` after that edge, and is visible after the next one.
- R7: With WIDTH = 4 and increments from reset, `src_gray` runs through 0000, 0001, 0011, 0010, 0110, 0111, 0101, 0100, 1100, 1101, 1111, 1110, 1010, 1011, 1001, 1000 and returns to 0000.
- R8: While the source counts freely, every value seen on `dst_bin` is one that `src_bin` held within the last few source cycles. No other value appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source-domain clock |
| src_rst | input | 1 | Source-domain synchronous reset, active high |
| src_inc | input | 1 | Advance the pointer by one on this edge |
| src_bin | output | WIDTH | Binary pointer, source domain |
| src_gray | output | WIDTH | Registered Gray form of the pointer, source domain |
| dst_clk | input | 1 | Destination-domain clock |
| dst_rst | input | 1 | Destination-domain synchronous reset, active high |
| dst_bin | output | WIDTH | Pointer decoded back to binary, destination domain |

## Verification
The assertions check the source-side rules on every edge: the step-by-one and hold behaviour, the wrap to zero, the agreement between the Gray and binary registers, and the single-bit change. On the destination side, an assertion checks that re-encoding `dst_bin` reproduces the synchronized Gray bus. Some properties span both clocks and only the bench scenarios can show them: the exact two-edge latency into the destination domain, the full 4-bit Gray order, and the rule that a pointer moving freely only ever lands on recent source values.

// File: rtl/gxp_pkg.sv
package gxp_pkg;
  localparam int MAX_W = 16;

  // Gray encoding on the widest supported word; callers zero-extend and truncate.
  function automatic logic [MAX_W-1:0] bin_to_gray(input logic [MAX_W-1:0] b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/gxp_src_counter.sv
module gxp_src_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] bin_q,
  output logic [W-1:0] gray_q
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ONES = '1;

  logic [W-1:0] bin_nx;
  assign bin_nx = bin_q + ONE;

  // Both registers load from the same next count on the same edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (inc) begin
      bin_q  <= bin_nx;
      gray_q <= W'(gxp_pkg::bin_to_gray(gxp_pkg::MAX_W'(bin_nx)));
    end
  end

  initial assert (W >= 2 && W <= gxp_pkg::MAX_W);

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    inc |=> bin_q == $past(bin_q) + ONE);
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !inc |=> ($stable(bin_q) && $stable(gray_q)));
  a_r3_gray_match: assert property (@(posedge clk) disable iff (rst)
    gray_q == (bin_q ^ (bin_q >> 1)));
  a_r4_one_bit: assert property (@(posedge clk) disable iff (rst)
    inc |=> $countones(gray_q ^ $past(gray_q)) == 1);
  a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
    (inc && bin_q == ONES) |=> bin_q == '0);
endmodule

// File: rtl/gxp_sync.sv
module gxp_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else if (s == 0) stg[s] <= d;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gxp_gray_decode.sv
module gxp_gray_decode #(
  parameter int W = 4
) (
  input  logic [W-1:0] gray,
  output logic [W-1:0] bin
);
  // Prefix XOR from the MSB down to each bit.
  for (genvar n = 0; n < W; n++) begin : g_bit
    assign bin[n] = ^gray[W-1:n];
  end
endmodule

// File: rtl/gray_ptr_xfer.sv
module gray_ptr_xfer #(
  parameter int WIDTH = 4
) (
  input  logic             src_clk,
  input  logic             src_rst,
  input  logic             src_inc,
  output logic [WIDTH-1:0] src_bin,
  output logic [WIDTH-1:0] src_gray,
  input  logic             dst_clk,
  input  logic             dst_rst,
  output logic [WIDTH-1:0] dst_bin
);
  localparam int SYNC_STAGES = 2;

  logic [WIDTH-1:0] dst_gray;

  gxp_src_counter #(.W(WIDTH)) u_cnt (
    .clk(src_clk), .rst(src_rst), .inc(src_inc),
    .bin_q(src_bin), .gray_q(src_gray)
  );

  gxp_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(dst_clk), .rst(dst_rst), .d(src_gray), .q(dst_gray)
  );

  gxp_gray_decode #(.W(WIDTH)) u_dec (
    .gray(dst_gray), .bin(dst_bin)
  );

  // R6: re-encoding the decoded value must give back the synchronized Gray word.
  a_r6_roundtrip: assert property (@(posedge dst_clk) disable iff (dst_rst)
    (dst_bin ^ (dst_bin >> 1)) == dst_gray);
  a_r1_dst_reset: assert property (@(posedge dst_clk)
    dst_rst |=> dst_bin == '0);
endmodule

// File: tb/gray_ptr_xfer_tb_top.sv
`timescale 1ns/1ps
module gray_ptr_xfer_tb_top;
  localparam int W = 4;

  logic src_clk = 1'b0, dst_clk = 1'b0;
  logic src_rst = 1'b1, dst_rst = 1'b1, src_inc = 1'b0;
  logic [W-1:0] src_bin, src_gray, dst_bin;

  int total = 0, bad = 0;
  logic [W-1:0] exp_bin = '0;
  logic [W-1:0] hist [8];

  always #2.5 src_clk = ~src_clk;
  always #3.5 dst_clk = ~dst_clk;

  gray_ptr_xfer #(.WIDTH(W)) dut_i (
    .src_clk(src_clk), .src_rst(src_rst), .src_inc(src_inc),
    .src_bin(src_bin), .src_gray(src_gray),
    .dst_clk(dst_clk), .dst_rst(dst_rst), .dst_bin(dst_bin)
  );

  // History of source pointer values, sampled away from the edge.
  always @(negedge src_clk) begin
    for (int i = 7; i > 0; i--) hist[i] <= hist[i-1];
    hist[0] <= src_bin;
  end

  function automatic logic [W-1:0] enc(input logic [W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic src_step(input logic inc);
    @(negedge src_clk); src_inc = inc;
    @(posedge src_clk);
    @(negedge src_clk);
    if (inc) exp_bin = exp_bin + 1'b1;
    src_inc = 1'b0;
  endtask

  task automatic t_reset();
    src_rst = 1'b1; dst_rst = 1'b1; src_inc = 1'b1;
    repeat (3) @(posedge dst_clk);
    @(negedge src_clk);
    check("R1 src_bin", src_bin, '0);
    check("R1 src_gray", src_gray, '0);
    @(negedge dst_clk);
    check("R1 dst_bin", dst_bin, '0);
    src_inc = 1'b0;
    @(negedge src_clk); src_rst = 1'b0;
    @(negedge dst_clk); dst_rst = 1'b0;
    exp_bin = '0;
  endtask

  task automatic t_count_hold();
    src_step(1'b1);
    check("R2 inc", src_bin, exp_bin);
    for (int i = 0; i < 3; i++) begin
      logic [W-1:0] g0;
      g0 = src_gray;
      src_step(1'b0);
      check("R2 hold bin", src_bin, exp_bin);
      check("R2 hold gray", src_gray, g0);
    end
  endtask

  task automatic t_sequence();
    logic [W-1:0] seq [16] = '{4'b0000, 4'b0001, 4'b0011, 4'b0010, 4'b0110, 4'b0111,
                               4'b0101, 4'b0100, 4'b1100, 4'b1101, 4'b1111, 4'b1110,
                               4'b1010, 4'b1011, 4'b1001, 4'b1000};
    t_reset();
    check("R7 start", src_gray, seq[0]);
    for (int i = 1; i <= 16; i++) begin
      logic [W-1:0] prev;
      prev = src_gray;
      src_step(1'b1);
      check("R7 order", src_gray, seq[i % 16]);
      check("R3 encode", src_gray, enc(exp_bin));
      total++;
      if ($countones(prev ^ src_gray) != 1) begin
        bad++;
        $display("FAIL R4 actual=%0d expected=1 bits changed", $countones(prev ^ src_gray));
      end
    end
  endtask

  task automatic t_wrap();
    t_reset();
    for (int i = 0; i < 15; i++) src_step(1'b1);
    check("R5 at ones", src_bin, 4'b1111);
    check("R5 gray at ones", src_gray, 4'b1000);
    src_step(1'b1);
    check("R5 wrapped bin", src_bin, 4'b0000);
    check("R5 wrapped gray", src_gray, 4'b0000);
  endtask

  task automatic t_latency();
    logic [W-1:0] old_v;
    repeat (4) @(posedge dst_clk);
    @(negedge dst_clk);
    old_v = dst_bin;
    check("R6 settled", dst_bin, src_bin);
    src_step(1'b1);
    @(posedge dst_clk); @(negedge dst_clk);
    check("R6 not after one edge", dst_bin, old_v);
    @(posedge dst_clk); @(negedge dst_clk);
    check("R6 after two edges", dst_bin, exp_bin);
    for (int k = 0; k < 5; k++) src_step(1'b1);
    repeat (3) @(posedge dst_clk);
    @(negedge dst_clk);
    check("R6 decode", dst_bin, exp_bin);
  endtask

  task automatic t_free_run();
    @(negedge src_clk); src_inc = 1'b1;
    repeat (10) @(negedge src_clk);
    for (int k = 0; k < 40; k++) begin
      logic hit;
      @(negedge dst_clk);
      hit = (dst_bin === src_bin);
      for (int i = 0; i < 8; i++) if (dst_bin === hist[i]) hit = 1'b1;
      total++;
      if (!hit) begin
        bad++;
        $display("FAIL R8 actual=%b expected=recent source value near %b", dst_bin, src_bin);
      end
    end
    @(negedge src_clk); src_inc = 1'b0;
  endtask

  initial begin
    t_reset();
    t_count_hold();
    t_sequence();
    t_wrap();
    t_latency();
    t_free_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule